// File: doc/BRIEF.md
# Critical-Word-First Line Filler

This unit services one cache miss at a time. A miss handler hands it a line address and the index of the 64-bit word the core is waiting for. The unit then issues a single whole-line fetch on a 128-bit memory port and tells memory which beat holds that word. Memory returns the line as four beats in wrapped order, starting with the beat that holds the demanded word. The demanded word goes to the core in the same cycle its beat arrives, so the core does not wait for the whole line.

While the beats arrive, each one is placed into a line buffer in natural order, whatever the starting beat was. Once all four beats are in, the rebuilt 64-byte line is written to the cache data array and completion is signalled for one cycle. Memory may leave gaps of any length between beats. Tag lookup, victim choice and coherence are handled elsewhere.

Top module: `cwf_line_filler`

## Requirements
- R1: While reset is held and in the first cycle after it, miss_ready_o is 1 and mem_req_valid_o, core_valid_o, fill_we_o and line_done_o are 0.
- R2: A miss is accepted on a clock edge where miss_valid_i and miss_ready_o are both 1. In the next cycle mem_req_valid_o is 1 for exactly one cycle, with mem_req_addr_o equal to the accepted line address and mem_req_beat_o equal to the requested word index shifted right by one (the critical beat).
- R3: From the cycle after acceptance through the line_done_o cycle, miss_ready_o is 0, and miss requests offered in that window cause no further memory request and do not alter the fill in progress.
- R4: Memory beats arrive in the order critical beat k, then (k+1) mod 4, (k+2) mod 4, (k+3) mod 4. In the cycle the first beat of a fill is offered with mem_beat_valid_i = 1, core_valid_o is 1 and core_word_o carries the requested word, which is bits [63:0] of the beat for an even word index and bits [127:64] for an odd one.
- R5: core_valid_o is 1 in exactly one cycle per fill.
- R6: The written line is in natural order: word i of the line occupies fill_line_o[i*64 +: 64], for every choice of critical word.
- R7: fill_we_o and line_done_o are 1 together for exactly one cycle, the cycle after the fourth beat is accepted, with fill_addr_o equal to the line address.
- R8: Any number of cycles with mem_beat_valid_i = 0 between beats, or before the first beat, leaves the delivered word and the written line unchanged, and core_valid_o stays 0 in those cycles.
- R9: A beat offered while the unit is idle, or in the cycle the memory request is issued, is ignored: core_valid_o stays 0 and the line of the next fill is unaffected.
- R10: miss_ready_o returns to 1 in the cycle after line_done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | Miss request offered |
| miss_ready_o | output | 1 | Unit can accept a miss |
| miss_addr_i | input | ADDR_W | Line address of the miss |
| miss_word_i | input | 3 | Index of the demanded word within the line |
| mem_req_valid_o | output | 1 | One-cycle whole-line fetch request |
| mem_req_addr_o | output | ADDR_W | Line address of the fetch |
| mem_req_beat_o | output | 2 | Beat that memory must return first |
| mem_beat_valid_i | input | 1 | Data beat present |
| mem_beat_data_i | input | 128 | Data beat |
| core_valid_o | output | 1 | Demanded word present |
| core_word_o | output | 64 | Demanded word |
| fill_we_o | output | 1 | Write the rebuilt line to the data array |
| fill_addr_o | output | ADDR_W | Line address for the write |
| fill_line_o | output | 512 | Rebuilt line, natural order |
| line_done_o | output | 1 | Fill complete |

## Verification
If the slot pointer or the latched critical beat is wrong, the fault appears only at the write, as a permuted or stale fill_line_o in the line_done_o cycle. That is four beat cycles after the first beat plus any stalls, so every critical-word position is tested with its own distinct line. A beat counter that is off by one, or a controller that takes beats outside the receive phase, shows up earlier. In that case line_done_o comes a cycle early or late, core_valid_o pulses twice, or junk accepted in an idle or request cycle ends up in the line. A controller that fails to return to idle keeps miss_ready_o low the cycle after completion, and the next fill detects this at once.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_RECV  = 2'd2,
    ST_WRITE = 2'd3
  } fill_state_e;
endpackage

// File: rtl/cwf_ctrl.sv
module cwf_ctrl
  import cwf_pkg::*;
#(
  parameter int BEATS = 4,
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             miss_valid_i,
  input  logic             beat_valid_i,
  output logic             miss_ready_o,
  output logic             accept_o,
  output logic             mem_req_o,
  output logic             take_o,
  output logic             first_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fill_o
);
  localparam logic [CNT_W-1:0] LastCnt = CNT_W'(BEATS - 1);

  fill_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign miss_ready_o = (state_q == ST_IDLE);
  assign accept_o     = miss_ready_o && miss_valid_i;
  assign mem_req_o    = (state_q == ST_REQ);
  assign take_o       = (state_q == ST_RECV) && beat_valid_i;
  assign first_o      = take_o && (cnt_q == '0);
  assign fill_o       = (state_q == ST_WRITE);
  assign cnt_o        = cnt_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE:  if (accept_o) state_d = ST_REQ;
      ST_REQ: begin
        state_d = ST_RECV;
        cnt_d   = '0;
      end
      ST_RECV: begin
        if (beat_valid_i) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LastCnt) state_d = ST_WRITE;
        end
      end
      ST_WRITE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/cwf_beat_store.sv
module cwf_beat_store #(
  parameter int BEATS  = 4,
  parameter int BEAT_W = 128,
  parameter int CNT_W  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [CNT_W-1:0]        crit_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic [BEAT_W-1:0]       data_i,
  output logic [BEATS*BEAT_W-1:0] line_o
);
  // wrapped arrival order -> natural slot
  logic [CNT_W-1:0] slot;
  assign slot = crit_i + cnt_i;

  for (genvar g = 0; g < BEATS; g++) begin : g_slot
    logic [BEAT_W-1:0] beat_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              beat_q <= '0;
      else if (wr_i && (slot == CNT_W'(g)))     beat_q <= data_i;
    end
    assign line_o[g*BEAT_W +: BEAT_W] = beat_q;
  end
endmodule

// File: rtl/cwf_word_pick.sv
module cwf_word_pick #(
  parameter int WPB    = 2,
  parameter int WORD_W = 64,
  parameter int WIDX_W = 3
) (
  input  logic [WPB*WORD_W-1:0] beat_i,
  input  logic [WIDX_W-1:0]     word_idx_i,
  output logic [WORD_W-1:0]     word_o
);
  logic [WIDX_W-1:0] lane;
  assign lane = word_idx_i & WIDX_W'(WPB - 1);

  always_comb begin
    word_o = '0;
    for (int i = 0; i < WPB; i++) begin
      if (lane == WIDX_W'(i)) word_o = beat_i[i*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/cwf_line_filler.sv
module cwf_line_filler #(
  parameter int ADDR_W     = 34,
  parameter int LINE_BYTES = 64,
  parameter int BEAT_W     = 128,
  parameter int WORD_W     = 64
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   miss_valid_i,
  output logic                                   miss_ready_o,
  input  logic [ADDR_W-1:0]                      miss_addr_i,
  input  logic [$clog2(LINE_BYTES*8/WORD_W)-1:0] miss_word_i,
  output logic                                   mem_req_valid_o,
  output logic [ADDR_W-1:0]                      mem_req_addr_o,
  output logic [$clog2(LINE_BYTES*8/BEAT_W)-1:0] mem_req_beat_o,
  input  logic                                   mem_beat_valid_i,
  input  logic [BEAT_W-1:0]                      mem_beat_data_i,
  output logic                                   core_valid_o,
  output logic [WORD_W-1:0]                      core_word_o,
  output logic                                   fill_we_o,
  output logic [ADDR_W-1:0]                      fill_addr_o,
  output logic [LINE_BYTES*8-1:0]                fill_line_o,
  output logic                                   line_done_o
);
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int BEATS  = LINE_W / BEAT_W;
  localparam int WPB    = BEAT_W / WORD_W;
  localparam int WORDS  = LINE_W / WORD_W;
  localparam int WIDX_W = $clog2(WORDS);
  localparam int CNT_W  = $clog2(BEATS);
  localparam int LANE_SH = $clog2(WPB);

  logic              accept, take, first, fill;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [WIDX_W-1:0] word_q;
  logic [CNT_W-1:0]  crit_beat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      word_q <= '0;
    end else if (accept) begin
      addr_q <= miss_addr_i;
      word_q <= miss_word_i;
    end
  end

  assign crit_beat = CNT_W'(word_q >> LANE_SH);

  cwf_ctrl #(.BEATS(BEATS), .CNT_W(CNT_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .miss_valid_i (miss_valid_i),
    .beat_valid_i (mem_beat_valid_i),
    .miss_ready_o (miss_ready_o),
    .accept_o     (accept),
    .mem_req_o    (mem_req_valid_o),
    .take_o       (take),
    .first_o      (first),
    .cnt_o        (cnt),
    .fill_o       (fill)
  );

  cwf_beat_store #(.BEATS(BEATS), .BEAT_W(BEAT_W), .CNT_W(CNT_W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (take),
    .crit_i (crit_beat),
    .cnt_i  (cnt),
    .data_i (mem_beat_data_i),
    .line_o (fill_line_o)
  );

  cwf_word_pick #(.WPB(WPB), .WORD_W(WORD_W), .WIDX_W(WIDX_W)) u_pick (
    .beat_i     (mem_beat_data_i),
    .word_idx_i (word_q),
    .word_o     (core_word_o)
  );

  assign mem_req_addr_o = addr_q;
  assign mem_req_beat_o = crit_beat;
  assign core_valid_o   = first;
  assign fill_we_o      = fill;
  assign line_done_o    = fill;
  assign fill_addr_o    = addr_q;
endmodule

// File: rtl/cwf_line_filler_chk.sv
module cwf_line_filler_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic miss_valid_i,
  input logic miss_ready_o,
  input logic mem_req_valid_o,
  input logic mem_beat_valid_i,
  input logic core_valid_o,
  input logic fill_we_o,
  input logic line_done_o
);
  logic core_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              core_seen_q <= 1'b0;
    else if (mem_req_valid_o) core_seen_q <= 1'b0;
    else if (core_valid_o)    core_seen_q <= 1'b1;
  end

  a_r2_req_follows_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && miss_ready_o) |=> mem_req_valid_o);
  a_r2_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |=> !mem_req_valid_o);
  a_r3_busy_in_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !miss_ready_o);
  a_r4_core_needs_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_valid_o |-> mem_beat_valid_i);
  a_r5_core_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_valid_o |-> !core_seen_q);
  a_r5_core_before_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |-> core_seen_q);
  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |=> !line_done_o);
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_ready_o |-> (!core_valid_o && !fill_we_o));
  a_r10_ready_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |=> miss_ready_o);
endmodule

bind cwf_line_filler cwf_line_filler_chk u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .miss_valid_i     (miss_valid_i),
  .miss_ready_o     (miss_ready_o),
  .mem_req_valid_o  (mem_req_valid_o),
  .mem_beat_valid_i (mem_beat_valid_i),
  .core_valid_o     (core_valid_o),
  .fill_we_o        (fill_we_o),
  .line_done_o      (line_done_o)
);

// File: tb/sim_cwf_line_filler.sv
module sim_cwf_line_filler;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         miss_valid_i = 1'b0;
  logic         miss_ready_o;
  logic [33:0]  miss_addr_i = '0;
  logic [2:0]   miss_word_i = '0;
  logic         mem_req_valid_o;
  logic [33:0]  mem_req_addr_o;
  logic [1:0]   mem_req_beat_o;
  logic         mem_beat_valid_i = 1'b0;
  logic [127:0] mem_beat_data_i = '0;
  logic         core_valid_o;
  logic [63:0]  core_word_o;
  logic         fill_we_o;
  logic [33:0]  fill_addr_o;
  logic [511:0] fill_line_o;
  logic         line_done_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cwf_line_filler u0 (.*);

  function automatic logic [63:0] wgen(logic [33:0] a, int i);
    return {a[31:0], 29'h0ABC_DE1, 3'(i)};
  endfunction

  function automatic logic [127:0] beat_of(logic [33:0] a, int b);
    return {wgen(a, 2*b+1), wgen(a, 2*b)};
  endfunction

  task automatic chk(string tag, logic [511:0] act, logic [511:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // one complete fill, memory model returns wrapped beat order
  task automatic do_fill(logic [33:0] a, int w, int s0, int s1, int s2, int s3,
                         bit pester, bit junk);
    int st[4];
    int crit;
    logic [511:0] exp_line;
    st = '{s0, s1, s2, s3};
    crit = w / 2;
    for (int i = 0; i < 8; i++) exp_line[i*64 +: 64] = wgen(a, i);
    @(negedge clk_i);
    chk("R10 ready before accept", 512'(miss_ready_o), 512'(1));
    miss_valid_i = 1'b1;
    miss_addr_i  = a;
    miss_word_i  = 3'(w);
    @(negedge clk_i);
    chk("R2 request valid", 512'(mem_req_valid_o), 512'(1));
    chk("R2 request addr", 512'(mem_req_addr_o), 512'(a));
    chk("R2 critical beat", 512'(mem_req_beat_o), 512'(crit));
    chk("R3 not ready in request", 512'(miss_ready_o), 512'(0));
    if (pester) begin
      miss_valid_i = 1'b1;
      miss_addr_i  = a ^ 34'h3;
      miss_word_i  = 3'(w + 3);
    end else begin
      miss_valid_i = 1'b0;
    end
    if (junk) begin
      mem_beat_valid_i = 1'b1;
      mem_beat_data_i  = {4{32'hDEAD_BEEF}};
      #1;
      chk("R9 beat in request cycle ignored", 512'(core_valid_o), 512'(0));
    end
    for (int j = 0; j < 4; j++) begin
      for (int k = 0; k < st[j]; k++) begin
        @(negedge clk_i);
        mem_beat_valid_i = 1'b0;
        mem_beat_data_i  = '0;
        #1;
        chk("R8 stall no core word", 512'(core_valid_o), 512'(0));
        chk("R3 no second request", 512'(mem_req_valid_o), 512'(0));
      end
      @(negedge clk_i);
      mem_beat_valid_i = 1'b1;
      mem_beat_data_i  = beat_of(a, (crit + j) % 4);
      #1;
      if (j == 0) begin
        chk("R4 core valid on first beat", 512'(core_valid_o), 512'(1));
        chk("R4 core word", 512'(core_word_o), 512'(wgen(a, w)));
      end else begin
        chk("R5 no repeat core pulse", 512'(core_valid_o), 512'(0));
      end
      chk("R3 busy while receiving", 512'(miss_ready_o), 512'(0));
      chk("R3 no second request", 512'(mem_req_valid_o), 512'(0));
    end
    @(negedge clk_i);
    mem_beat_valid_i = 1'b0;
    mem_beat_data_i  = '0;
    miss_valid_i     = 1'b0;
    chk("R7 line done", 512'(line_done_o), 512'(1));
    chk("R7 write enable", 512'(fill_we_o), 512'(1));
    chk("R7 write addr", 512'(fill_addr_o), 512'(a));
    chk("R6 natural order line", fill_line_o, exp_line);
    chk("R3 busy at done", 512'(miss_ready_o), 512'(0));
    @(negedge clk_i);
    chk("R7 done single cycle", 512'(line_done_o), 512'(0));
    chk("R7 write single cycle", 512'(fill_we_o), 512'(0));
    chk("R10 ready after done", 512'(miss_ready_o), 512'(1));
  endtask

  task automatic t_reset();
    #(CLK_PERIOD*2 + 1);
    chk("R1 ready in reset", 512'(miss_ready_o), 512'(1));
    chk("R1 no request in reset", 512'(mem_req_valid_o), 512'(0));
    chk("R1 no core in reset", 512'(core_valid_o), 512'(0));
    chk("R1 no write in reset", 512'(fill_we_o), 512'(0));
    chk("R1 no done in reset", 512'(line_done_o), 512'(0));
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 ready after reset", 512'(miss_ready_o), 512'(1));
    chk("R1 no request after reset", 512'(mem_req_valid_o), 512'(0));
  endtask

  task automatic t_every_critical_word();
    for (int w = 0; w < 8; w++) do_fill(34'h1_2345_0000 + 34'(w*17), w, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_stalls();
    do_fill(34'h2_0F0F_1234, 5, 4, 2, 0, 3, 0, 0);
    do_fill(34'h0_0000_0001, 2, 0, 5, 1, 0, 0, 0);
  endtask

  task automatic t_busy_requests();
    do_fill(34'h3_AAAA_5555, 7, 0, 1, 0, 2, 1, 0);
  endtask

  task automatic t_ignored_beats();
    @(negedge clk_i);
    mem_beat_valid_i = 1'b1;
    mem_beat_data_i  = {4{32'hBAD0_BAD0}};
    #1;
    chk("R9 idle beat no core word", 512'(core_valid_o), 512'(0));
    chk("R9 idle beat no write", 512'(fill_we_o), 512'(0));
    @(negedge clk_i);
    mem_beat_valid_i = 1'b0;
    mem_beat_data_i  = '0;
    do_fill(34'h1_FFFF_FFC0, 3, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    t_reset();
    t_every_critical_word();
    t_stalls();
    t_busy_requests();
    t_ignored_beats();
    finish_up();
  end

  initial begin
    #(CLK_PERIOD*150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end
endmodule